// File: doc/BRIEF.md
# Bus Command FIFO Engine

This block sits between a host register interface and the command path of a two-wire audio bus master. Software writes packed 32-bit command words into one of two command registers, one for writes and one for reads. The block queues them and runs each against a device on the far side as a series of single-byte transactions. Each transaction uses a request that is held until the device answers, and the answer carries an ok flag and a data byte.

Read commands fetch a burst of up to 15 consecutive bytes. The bytes land in a byte-wide read FIFO, and the host pops them one access at a time. A failed transaction is retried up to a programmable count. When the retries run out, the engine raises an error and stops until software flushes the command path. A command tagged with the reserved ID 0xF raises a completion event when it finishes. Completion, error and device attachment events collect in a 17-bit sticky status register. A mask register and a write-1-to-clear register sit beside it, and a level interrupt output is driven from the masked status.

Top module: `bus_cmd_engine`

## Requirements
- R1: A command word holds the register address in bits 15:0, the command ID in bits 19:16, the device number in bits 23:20 and the write data in bits 31:24. Writing the word to offset 0x0 queues a write. Queued commands are issued to the device in the order they were written.
- R2: A command word written to offset 0x1 queues a read whose byte count is in bits 31:24. The read issues that many single-byte reads at ascending addresses, wrapping at 16 bits. A count of 0 completes without any device transaction.
- R3: A read command with a count above 15 is rejected. It is not queued, it issues no transaction, and it sets status bit 7.
- R4: Each host read of offset 0x7 pops one returned byte into bits 7:0, oldest byte first. A read of an empty read FIFO returns 0.
- R5: When a command with ID 0xF completes, status bit 10 is set. Commands with any other ID leave bit 10 unchanged.
- R6: Offset 0x3 holds the retry count in bits 3:0, reset value 7. A transaction answered with ok low is repeated until it succeeds or until it has been tried retry count + 1 times.
- R7: When the last permitted attempt fails, status bit 7 is set and the engine halts. Commands still queued, or queued later, are not issued while it is halted.
- R8: Writing 1 to bit 0 of offset 0x2 discards the command queue and the read FIFO and takes the engine out of the halt. Commands queued afterwards run normally.
- R9: The command queue holds 8 commands. A command written while the queue is full is dropped and sets status bit 7.
- R10: The status register at offset 0x4 is 17 bits wide and 0 after reset. The attach input sets bit 1 and the enumeration-change input sets bit 2. Writing ones to offset 0x6 clears those bits, and an event in the same cycle as a clear wins.
- R11: The mask register at offset 0x5 is 0 after reset. The irq output is high exactly when some status bit and its mask bit are both 1.
- R12: Offset 0x8 returns the device status input, 2 bits per device number packed from bit 0 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (pops the read FIFO at offset 0x7) |
| host_addr | input | 4 | Register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid in the cycle of the access |
| dev_req_valid | output | 1 | Transaction request, held until answered |
| dev_req_write | output | 1 | 1 for a write transaction, 0 for a read |
| dev_req_dev | output | 4 | Target device number |
| dev_req_addr | output | 16 | Target register address |
| dev_req_wdata | output | 8 | Write data byte |
| dev_rsp_valid | input | 1 | Device answer strobe |
| dev_rsp_ok | input | 1 | Answer ok flag; 0 marks a failed attempt |
| dev_rsp_data | input | 8 | Byte returned for a read |
| attach_evt | input | 1 | Newly attached device event |
| enum_chg_evt | input | 1 | Enumerated device status change event |
| dev_status | input | 32 | Per-device status, 2 bits per device |
| irq | output | 1 | Level interrupt from masked status |

## Verification
A queue pointer that slips shows at the device port within one transaction: the device sees the wrong address, data or order, or sees an extra or missing request. A wrong retry counter shows as an attempt count, observed at the device, that differs from retry count + 1, or as a halt that comes too early or too late. Read FIFO faults show in the first popped byte after the burst completes. A halt that fails to hold, or a flush that fails to clear, shows in the device transaction log within a few tens of cycles.

// File: rtl/bce_pkg.sv
// Shared definitions for the bus command engine: register offsets,
// status bit positions and the queued command record.
package bce_pkg;
    localparam int STAT_W      = 17;
    localparam int MAX_RD_LEN  = 15;
    localparam logic [3:0] SPECIAL_ID = 4'hF;

    localparam logic [3:0] OFS_CMD_WR  = 4'h0;
    localparam logic [3:0] OFS_CMD_RD  = 4'h1;
    localparam logic [3:0] OFS_CTRL    = 4'h2;
    localparam logic [3:0] OFS_RETRY   = 4'h3;
    localparam logic [3:0] OFS_STATUS  = 4'h4;
    localparam logic [3:0] OFS_MASK    = 4'h5;
    localparam logic [3:0] OFS_CLEAR   = 4'h6;
    localparam logic [3:0] OFS_RDFIFO  = 4'h7;
    localparam logic [3:0] OFS_DEVSTAT = 4'h8;

    localparam int BIT_ATTACH  = 1;
    localparam int BIT_ENUMCHG = 2;
    localparam int BIT_ERROR   = 7;
    localparam int BIT_SPECIAL = 10;

    typedef struct packed {
        logic        is_rd;
        logic [7:0]  dat;
        logic [3:0]  dev;
        logic [3:0]  id;
        logic [15:0] addr;
    } cmd_t;
endpackage

// File: rtl/bce_fifo.sv
// Generic synchronous FIFO used for the command queue and the read data.
// Assumes DEPTH is a power of two and that the caller never pushes when
// full nor pops when empty. Flush empties it in one cycle.
module bce_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;

    assign full  = (cnt == CNT_W'(DEPTH));
    assign empty = (cnt == '0);
    assign dout  = mem[rp];

    // Storage write on push.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |-> !full);   // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush) |-> !empty);   // R4
endmodule

// File: rtl/bce_engine.sv
// Command execution engine. Pops one command at a time and splits it into
// single-byte device transactions, retries failed ones, pushes read bytes
// to the read FIFO and halts on an exhausted retry until flushed.
// Assumes read lengths were limited to MAX_RD_LEN before queueing.
module bce_engine
    import bce_pkg::*;
#(
    parameter int RETRY_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [RETRY_W-1:0] retry_lim,
    input  logic               cmd_valid,
    input  cmd_t               cmd_head,
    output logic               cmd_pop,
    input  logic               rdf_full,
    output logic               rdf_push,
    output logic [7:0]         rdf_data,
    output logic               req_valid,
    output logic               req_write,
    output logic [3:0]         req_dev,
    output logic [15:0]        req_addr,
    output logic [7:0]         req_wdata,
    input  logic               rsp_valid,
    input  logic               rsp_ok,
    input  logic [7:0]         rsp_data,
    output logic               done_special,
    output logic               cmd_fail
);
    typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_HALT} st_t;

    st_t                state;
    cmd_t               cur;
    logic [3:0]         left;
    logic [RETRY_W-1:0] tries;
    logic               hit;

    assign cmd_pop   = (state == ST_IDLE) && cmd_valid && !flush;
    assign req_valid = (state == ST_XFER) && !(cur.is_rd && rdf_full);
    assign req_write = !cur.is_rd;
    assign req_dev   = cur.dev;
    assign req_addr  = cur.addr;
    assign req_wdata = cur.dat;
    assign hit       = req_valid && rsp_valid;
    assign rdf_push  = hit && rsp_ok && cur.is_rd && !flush;
    assign rdf_data  = rsp_data;

    // Command sequencing, retry accounting and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            cur          <= '0;
            left         <= '0;
            tries        <= '0;
            done_special <= 1'b0;
            cmd_fail     <= 1'b0;
        end else begin
            done_special <= 1'b0;
            cmd_fail     <= 1'b0;
            if (flush) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: if (cmd_valid) begin
                        cur   <= cmd_head;
                        tries <= retry_lim;
                        left  <= cmd_head.is_rd ? cmd_head.dat[3:0] : 4'd1;
                        if (cmd_head.is_rd && cmd_head.dat[3:0] == 4'd0)
                            done_special <= (cmd_head.id == SPECIAL_ID);
                        else
                            state <= ST_XFER;
                    end
                    ST_XFER: if (hit) begin
                        if (rsp_ok) begin
                            cur.addr <= cur.addr + 16'd1;
                            tries    <= retry_lim;
                            left     <= left - 4'd1;
                            if (left == 4'd1) begin
                                done_special <= (cur.id == SPECIAL_ID);
                                state        <= ST_IDLE;
                            end
                        end else if (tries == '0) begin
                            cmd_fail <= 1'b1;
                            state    <= ST_HALT;
                        end else begin
                            tries <= tries - 1'b1;
                        end
                    end
                    default: state <= ST_HALT;
                endcase
            end
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_valid && !flush) |=> ($stable(req_addr) && $stable(req_dev)));   // R1
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> (!req_valid && !cmd_pop));   // R7
    AST_RD_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        rdf_push |=> (req_addr == $past(req_addr) + 16'd1));   // R2
    AST_FAIL_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fail && !flush) |-> (state == ST_HALT));   // R7
endmodule

// File: rtl/bce_irq.sv
// Sticky interrupt status with write-1-to-clear, mask register and level
// interrupt. An event arriving in the cycle of a clear keeps its bit set.
module bce_irq #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_ev,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_bits,
    input  logic         mask_wr,
    input  logic [W-1:0] mask_bits,
    output logic [W-1:0] status,
    output logic [W-1:0] mask,
    output logic         irq
);
    // Status accumulation and clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~(clr_wr ? clr_bits : '0)) | set_ev;
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_wr) mask <= mask_bits;
    end

    assign irq = |(status & mask);

    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && ((clr_bits & set_ev) == '0)) |=> ((status & $past(clr_bits)) == '0));   // R10
    AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_ev) |=> ((status & $past(set_ev)) == $past(set_ev)));   // R10
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);   // R11
endmodule

// File: rtl/bus_cmd_engine.sv
// Top of the bus command engine: host register decode, command queue,
// read data FIFO, execution engine and interrupt status. Host reads are
// combinational; a read of the read-FIFO offset pops one byte.
module bus_cmd_engine
    import bce_pkg::*;
#(
    parameter int QDEPTH    = 8,
    parameter int RDDEPTH   = 16,
    parameter int RETRY_W   = 4,
    parameter int RETRY_DEF = 7,
    parameter int NDEV      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [3:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        dev_req_valid,
    output logic        dev_req_write,
    output logic [3:0]  dev_req_dev,
    output logic [15:0] dev_req_addr,
    output logic [7:0]  dev_req_wdata,
    input  logic        dev_rsp_valid,
    input  logic        dev_rsp_ok,
    input  logic [7:0]  dev_rsp_data,
    input  logic        attach_evt,
    input  logic        enum_chg_evt,
    input  logic [2*NDEV-1:0] dev_status,
    output logic        irq
);
    localparam int CMD_W = $bits(cmd_t);

    logic               wr_cmd, rd_cmd, len_bad, want_push;
    logic               q_push, q_pop, q_full, q_empty;
    logic               flush, drop_ev, reject_ev;
    logic [CMD_W-1:0]   q_dout;
    cmd_t               q_din, q_head;
    logic               rdf_push, rdf_pop, rdf_full, rdf_empty;
    logic [7:0]         rdf_din, rdf_dout;
    logic [RETRY_W-1:0] retry_q;
    logic               done_special, cmd_fail;
    logic [STAT_W-1:0]  set_ev, status, mask;

    assign wr_cmd    = host_wr && (host_addr == OFS_CMD_WR);
    assign rd_cmd    = host_wr && (host_addr == OFS_CMD_RD);
    assign len_bad   = (host_wdata[31:24] > 8'(MAX_RD_LEN));
    assign want_push = wr_cmd || (rd_cmd && !len_bad);
    assign q_push    = want_push && !q_full;
    assign drop_ev   = want_push && q_full;
    assign reject_ev = rd_cmd && len_bad;
    assign flush     = host_wr && (host_addr == OFS_CTRL) && host_wdata[0];
    assign rdf_pop   = host_rd && (host_addr == OFS_RDFIFO) && !rdf_empty;

    assign q_din  = '{is_rd: rd_cmd, dat: host_wdata[31:24], dev: host_wdata[23:20],
                      id: host_wdata[19:16], addr: host_wdata[15:0]};
    assign q_head = cmd_t'(q_dout);

    // Retry count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            retry_q <= RETRY_W'(RETRY_DEF);
        else if (host_wr && host_addr == OFS_RETRY)
            retry_q <= host_wdata[RETRY_W-1:0];
    end

    // Event vector feeding the status register.
    always_comb begin
        set_ev              = '0;
        set_ev[BIT_ATTACH]  = attach_evt;
        set_ev[BIT_ENUMCHG] = enum_chg_evt;
        set_ev[BIT_ERROR]   = cmd_fail || drop_ev || reject_ev;
        set_ev[BIT_SPECIAL] = done_special;
    end

    // Host read data selection.
    always_comb begin
        case (host_addr)
            OFS_RETRY:   host_rdata = 32'(retry_q);
            OFS_STATUS:  host_rdata = 32'(status);
            OFS_MASK:    host_rdata = 32'(mask);
            OFS_RDFIFO:  host_rdata = rdf_empty ? 32'd0 : 32'(rdf_dout);
            OFS_DEVSTAT: host_rdata = 32'(dev_status);
            default:     host_rdata = 32'd0;
        endcase
    end

    bce_fifo #(.W(CMD_W), .DEPTH(QDEPTH)) u_cmdq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(q_push), .din(q_din), .pop(q_pop),
        .dout(q_dout), .full(q_full), .empty(q_empty)
    );

    bce_fifo #(.W(8), .DEPTH(RDDEPTH)) u_rdf (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(rdf_push), .din(rdf_din), .pop(rdf_pop),
        .dout(rdf_dout), .full(rdf_full), .empty(rdf_empty)
    );

    bce_engine #(.RETRY_W(RETRY_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .flush(flush), .retry_lim(retry_q),
        .cmd_valid(!q_empty), .cmd_head(q_head), .cmd_pop(q_pop),
        .rdf_full(rdf_full), .rdf_push(rdf_push), .rdf_data(rdf_din),
        .req_valid(dev_req_valid), .req_write(dev_req_write),
        .req_dev(dev_req_dev), .req_addr(dev_req_addr), .req_wdata(dev_req_wdata),
        .rsp_valid(dev_rsp_valid), .rsp_ok(dev_rsp_ok), .rsp_data(dev_rsp_data),
        .done_special(done_special), .cmd_fail(cmd_fail)
    );

    bce_irq #(.W(STAT_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_ev(set_ev),
        .clr_wr(host_wr && host_addr == OFS_CLEAR), .clr_bits(host_wdata[STAT_W-1:0]),
        .mask_wr(host_wr && host_addr == OFS_MASK), .mask_bits(host_wdata[STAT_W-1:0]),
        .status(status), .mask(mask), .irq(irq)
    );

    AST_REJECT_NOQ: assert property (@(posedge clk) disable iff (!rst_n)
        reject_ev |-> !q_push);   // R3
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        drop_ev |=> status[BIT_ERROR]);   // R9
endmodule

// File: tb/sim_bus_cmd_engine.sv
// Self-checking bench: a behavioural device model with random latency and
// injectable failures, directed corner cases and a seeded random mix.
module sim_bus_cmd_engine;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_CYC   = 160;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        dev_req_valid, dev_req_write;
    logic [3:0]  dev_req_dev;
    logic [15:0] dev_req_addr;
    logic [7:0]  dev_req_wdata;
    logic        dev_rsp_valid = 1'b0, dev_rsp_ok = 1'b0;
    logic [7:0]  dev_rsp_data = '0;
    logic        attach_evt = 1'b0, enum_chg_evt = 1'b0;
    logic [31:0] dev_status = '0;
    logic        irq;

    int nchk = 0, nerr = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cmd_engine u0 (.*);

    // Device model state.
    int         n_hs = 0, fails_done = 0, fail_target = 0, wlog_n = 0;
    logic [3:0] wlog_dev [256];
    logic [15:0] wlog_addr [256];
    logic [7:0] wlog_dat [256];
    bit         busy = 0;
    int         lat = 0;

    function automatic logic [7:0] exp_byte(logic [3:0] d, logic [15:0] a);
        return {d, 4'h0} ^ a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // Device model: random latency answer, failure injection, write log.
    always @(posedge clk) begin
        if (!rst_n) begin
            dev_rsp_valid <= 1'b0;
            busy <= 0;
        end else if (dev_rsp_valid) begin
            dev_rsp_valid <= 1'b0;
            if (dev_req_valid) begin
                n_hs <= n_hs + 1;
                if (dev_rsp_ok && dev_req_write) begin
                    wlog_dev[wlog_n % 256]  <= dev_req_dev;
                    wlog_addr[wlog_n % 256] <= dev_req_addr;
                    wlog_dat[wlog_n % 256]  <= dev_req_wdata;
                    wlog_n <= wlog_n + 1;
                end
            end
        end else if (busy) begin
            if (lat == 0) begin
                busy <= 0;
                dev_rsp_valid <= 1'b1;
                dev_rsp_ok    <= (fails_done >= fail_target);
                if (fails_done < fail_target) fails_done <= fails_done + 1;
                dev_rsp_data  <= exp_byte(dev_req_dev, dev_req_addr);
            end else begin
                lat <= lat - 1;
            end
        end else if (dev_req_valid) begin
            busy <= 1;
            lat  <= $urandom_range(0, 2);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hwrite(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    function automatic logic [31:0] pack(logic [7:0] dat, logic [3:0] dev,
                                         logic [3:0] id, logic [15:0] addr);
        return {dat, dev, id, addr};
    endfunction

    task automatic do_write(input logic [3:0] dev, input logic [3:0] id,
                            input logic [15:0] addr, input logic [7:0] dat);
        int n0;
        n0 = wlog_n;
        hwrite(4'h0, pack(dat, dev, id, addr));
        idle(40);
        chk("R1 write count", 32'(wlog_n - n0), 32'd1);
        chk("R1 write fields", {4'h0, wlog_dev[n0 % 256], wlog_addr[n0 % 256], wlog_dat[n0 % 256]},
            {4'h0, dev, addr, dat});
    endtask

    task automatic do_read(input logic [3:0] dev, input logic [15:0] addr, input int len);
        logic [31:0] v;
        hwrite(4'h1, pack(8'(len), dev, 4'h2, addr));
        idle(WAIT_CYC);
        for (int i = 0; i < len; i++) begin
            hread(4'h7, v);
            chk("R2 R4 read byte", v, 32'(exp_byte(dev, addr + 16'(i))));
        end
        hread(4'h7, v);
        chk("R4 empty read", v, 32'd0);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int h0, w0;
        void'($urandom(32'd4711));
        dev_status = 32'hA5C3_1E72;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state.
        #1 chk("R11 irq after reset", 32'(irq), 32'd0);
        hread(4'h4, v); chk("R10 status reset", v, 32'd0);
        hread(4'h5, v); chk("R11 mask reset", v, 32'd0);
        hread(4'h3, v); chk("R6 retry reset", v, 32'd7);
        hread(4'h7, v); chk("R4 empty after reset", v, 32'd0);
        hread(4'h8, v); chk("R12 device status", v, 32'hA5C3_1E72);

        // Plain write, non-special ID.
        do_write(4'h5, 4'h3, 16'h1234, 8'hBE);
        hread(4'h4, v); chk("R5 no special bit", v, 32'd0);

        // Special ID write.
        do_write(4'h9, 4'hF, 16'h0042, 8'h11);
        hread(4'h4, v); chk("R5 special bit", v, 32'h400);
        hwrite(4'h6, 32'h400);
        hread(4'h4, v); chk("R10 clear", v, 32'd0);

        // Mask and interrupt level.
        hwrite(4'h5, 32'h400);
        do_write(4'h1, 4'hF, 16'h0007, 8'h22);
        #1 chk("R11 irq masked in", 32'(irq), 32'd1);
        hwrite(4'h6, 32'h400);
        #1 chk("R11 irq after clear", 32'(irq), 32'd0);
        @(negedge clk); attach_evt = 1'b1; @(negedge clk); attach_evt = 1'b0;
        @(negedge clk); enum_chg_evt = 1'b1; @(negedge clk); enum_chg_evt = 1'b0;
        idle(2);
        hread(4'h4, v); chk("R10 attach and change bits", v, 32'h6);
        #1 chk("R11 irq unmasked bits", 32'(irq), 32'd0);
        hwrite(4'h5, 32'h2);
        #1 chk("R11 irq bit1", 32'(irq), 32'd1);
        // Clear together with a new attach event: event wins.
        @(negedge clk);
        host_wr = 1'b1; host_addr = 4'h6; host_wdata = 32'h6; attach_evt = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; attach_evt = 1'b0;
        hread(4'h4, v); chk("R10 set wins over clear", v, 32'h2);
        hwrite(4'h6, 32'h1FFFF);
        hwrite(4'h5, 32'h0);

        // Zero length read with special ID.
        h0 = n_hs;
        hwrite(4'h1, pack(8'd0, 4'h3, 4'hF, 16'h0100));
        idle(20);
        chk("R2 zero length no transaction", 32'(n_hs - h0), 32'd0);
        hread(4'h4, v); chk("R2 R5 zero length completes", v, 32'h400);
        hwrite(4'h6, 32'h400);

        // Full length read across the address wrap.
        do_read(4'h6, 16'hFFF8, 15);

        // Over-long read rejected.
        h0 = n_hs;
        hwrite(4'h1, pack(8'd16, 4'h2, 4'h1, 16'h0010));
        idle(30);
        chk("R3 no transaction", 32'(n_hs - h0), 32'd0);
        hread(4'h4, v); chk("R3 error bit", v, 32'h80);
        hread(4'h7, v); chk("R3 no data", v, 32'd0);
        hwrite(4'h6, 32'h80);

        // Retries that eventually succeed.
        hwrite(4'h3, 32'd2);
        hread(4'h3, v); chk("R6 retry readback", v, 32'd2);
        fail_target = fails_done + 2;
        h0 = n_hs;
        do_write(4'h4, 4'h0, 16'h0200, 8'h5A);
        chk("R6 attempts", 32'(n_hs - h0), 32'd3);
        hread(4'h4, v); chk("R6 no error", v, 32'd0);

        // Retries exhausted: error and halt.
        fail_target = fails_done + 3;
        h0 = n_hs; w0 = wlog_n;
        hwrite(4'h0, pack(8'h77, 4'h4, 4'h0, 16'h0300));
        idle(60);
        chk("R7 attempts", 32'(n_hs - h0), 32'd3);
        chk("R7 no write logged", 32'(wlog_n - w0), 32'd0);
        hread(4'h4, v); chk("R7 error bit", v, 32'h80);
        hwrite(4'h0, pack(8'h78, 4'h4, 4'h0, 16'h0301));
        idle(60);
        chk("R7 halted, nothing issued", 32'(n_hs - h0), 32'd3);

        // Fill the queue while halted.
        hwrite(4'h6, 32'h80);
        for (int i = 0; i < 7; i++) hwrite(4'h0, pack(8'(i), 4'h1, 4'h0, 16'(i)));
        hread(4'h4, v); chk("R9 eight fit", v, 32'd0);
        hwrite(4'h0, pack(8'hEE, 4'h1, 4'h0, 16'h00EE));
        hread(4'h4, v); chk("R9 ninth dropped", v, 32'h80);
        hwrite(4'h6, 32'h80);

        // Flush discards the queue and resumes.
        hwrite(4'h2, 32'h1);
        idle(60);
        chk("R8 queue discarded", 32'(n_hs - h0), 32'd3);
        chk("R8 no writes", 32'(wlog_n - w0), 32'd0);
        hwrite(4'h3, 32'd7);
        do_write(4'h2, 4'h5, 16'h0ABC, 8'hC3);
        hwrite(4'h1, pack(8'd3, 4'h2, 4'h0, 16'h0040));
        idle(60);
        hwrite(4'h2, 32'h1);
        hread(4'h7, v); chk("R8 read fifo emptied", v, 32'd0);

        // Seeded random mix.
        for (int it = 0; it < 30; it++) begin
            logic [3:0] rd; logic [15:0] ra;
            rd = 4'($urandom); ra = 16'($urandom);
            if ($urandom_range(0, 1) == 0)
                do_write(rd, 4'($urandom_range(0, 14)), ra, 8'($urandom));
            else
                do_read(rd, ra, $urandom_range(1, 15));
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
        $finish;
    end
endmodule